// File: doc/BRIEF.md
# Low-Address Protection and Prefix Mapping Unit

This unit sits beside an address translation path and handles two checks that do not need a table walk. The first is low-address protection, which guards two 512-byte windows at the bottom of storage against stores. The second is prefixing, which turns a real address into an absolute one through a programmable prefix register. Each request carries one address, an access kind and the control state that decides whether protection is armed. One cycle later the unit returns the absolute address, a protection-exception flag, an error flag for an unsupported address-space selection, and a hint that says the write permission of the page must not be cached.

Prefixing exchanges the first 8 KiB of real storage with the 8 KiB block at the prefix, in both directions. Every other address passes through unchanged. The prefix register is loaded through its own write-enable port and always holds an 8 KiB aligned value. The same request address feeds both the protection test and the prefix mapping.

Top module: `lapp_unit`

## Requirements
- R1: A byte address is in the protected window when it lies in 0..511 or 4096..4607, both ends included. When protection is enabled, a store to such an address sets protExc. A store to 512, 4095, 4608 or 8192 does not set it.
- R2: In translated mode (realMode=0), protection is enabled only when lowProtCtl=1, datOn=1 and the private bit of the selected space is 0. The space codes are spaceSel 0 primary, 1 secondary and 2 home. Their private bits are privBits[0], privBits[1] and privBits[2].
- R3: In real mode (realMode=1), protection is enabled by lowProtCtl alone. datOn, privBits and spaceSel have no effect on it.
- R4: When protection is enabled and the address lies in page 0 or page 1 (address below 0x2000), noWriteCache is set for every access kind. Otherwise it stays clear.
- R5: protExc is raised only for accKind 1 (store). Kinds 0 (data fetch), 2 (instruction fetch) and 3 never raise it.
- R6: A response with protExc set reports absAddr = 0.
- R7: A real address below 0x2000 maps to the address plus the prefix.
- R8: An address from the prefix up to, but not including, prefix+0x2000 maps to the address minus the prefix. Every other address is returned unchanged.
- R9: The prefix resets to 0. A write stores prefixIn with its low 13 bits cleared. A request in the same cycle as the write still uses the old prefix, and the next request uses the new one.
- R10: In translated mode, spaceSel 3 sets modeErr and suppresses the access: protExc=0, noWriteCache=0 and absAddr=0. In real mode, spaceSel 3 raises no error.
- R11: Each request accepted at a clock edge produces its response one cycle later with rspValid=1, and back-to-back requests are allowed. While rspValid=0, all other outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqAddr | input | ADDR_W | Address under test and to be prefixed |
| accKind | input | 2 | 0 fetch, 1 store, 2 instruction fetch, 3 none |
| realMode | input | 1 | 1 selects the real-address variant |
| datOn | input | 1 | Translation enabled |
| spaceSel | input | 2 | 0 primary, 1 secondary, 2 home, 3 unsupported |
| privBits | input | 3 | Private-space bits: [0] primary, [1] secondary, [2] home |
| lowProtCtl | input | 1 | Low-address protection control bit |
| prefixWe | input | 1 | Load the prefix register |
| prefixIn | input | ADDR_W | New prefix value |
| rspValid | output | 1 | Response valid |
| absAddr | output | ADDR_W | Absolute address |
| protExc | output | 1 | Protection exception (exception code zero) |
| noWriteCache | output | 1 | Page write permission must not be cached |
| modeErr | output | 1 | Unsupported address-space selection |

## Verification
Some rules are checked by the assertions on every cycle. A protection hit always also flags its page. An error response never carries a hit, a flag or an address. An exception response carries a zero address. Every request is answered in the next cycle, and the outputs are quiet between responses. Only the bench scenarios can show the exact window edges (511/512, 4095/4096, 4607/4608) and the enable combinations for each space. They also cover the two directions of the prefix swap, the pass-through above and below the prefix area, and the timing of a prefix write against a request in the same cycle.

// File: rtl/lapp_pkg.sv
package lapp_pkg;

  typedef enum logic [1:0] {
    ACC_FETCH  = 2'd0,
    ACC_STORE  = 2'd1,
    ACC_IFETCH = 2'd2,
    ACC_NONE   = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    SPC_PRIMARY   = 2'd0,
    SPC_SECONDARY = 2'd1,
    SPC_HOME      = 2'd2,
    SPC_BAD       = 2'd3
  } space_e;

  typedef struct packed {
    logic protHit;
    logic noCache;
    logic modeErr;
  } lapp_strobe_t;

endpackage

// File: rtl/lapp_ctrl.sv
module lapp_ctrl
  import lapp_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int WIN_BITS  = 9,
  parameter int LOW_PAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        accKind,
  input  logic              realMode,
  input  logic              datOn,
  input  logic [1:0]        spaceSel,
  input  logic [2:0]        privBits,
  input  logic              lowProtCtl,
  output lapp_strobe_t      strb
);

  localparam int PN_W = ADDR_W - PAGE_BITS;

  logic [PN_W-1:0] pageNum;
  logic            inLowPage;
  logic            inWindow;
  logic            badSpace;
  logic            privSel;
  logic            protEnable;

  assign pageNum   = reqAddr[ADDR_W-1:PAGE_BITS];
  assign inLowPage = pageNum < PN_W'(LOW_PAGES);
  assign inWindow  = inLowPage && (reqAddr[PAGE_BITS-1:WIN_BITS] == '0);
  assign badSpace  = !realMode && (spaceSel == SPC_BAD);

  always_comb begin
    case (spaceSel)
      SPC_PRIMARY:   privSel = privBits[0];
      SPC_SECONDARY: privSel = privBits[1];
      SPC_HOME:      privSel = privBits[2];
      default:       privSel = 1'b0;
    endcase
  end

  assign protEnable = realMode ? lowProtCtl
                               : (lowProtCtl && datOn && !privSel);

  always_comb begin
    strb.modeErr = reqValid && badSpace;
    strb.noCache = reqValid && !badSpace && protEnable && inLowPage;
    strb.protHit = reqValid && !badSpace && protEnable && inWindow &&
                   (accKind == ACC_STORE);
  end

  AST_HIT_FLAGS_PAGE: assert property (@(posedge clk) disable iff (!rstN)
    strb.protHit |-> strb.noCache); // R4

  AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    strb.modeErr |-> (!strb.protHit && !strb.noCache)); // R10

endmodule

// File: rtl/lapp_datapath.sv
module lapp_datapath
  import lapp_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int PREFIX_BITS = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  lapp_strobe_t      strb,
  input  logic              prefixWe,
  input  logic [ADDR_W-1:0] prefixIn,
  output logic              rspValid,
  output logic [ADDR_W-1:0] absAddr,
  output logic              protExc,
  output logic              noWriteCache,
  output logic              modeErr
);

  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(1) << PREFIX_BITS;

  logic [ADDR_W-1:0] prefixReg;
  logic [ADDR_W-1:0] mapped;
  logic [ADDR_W-1:0] offsetFromPrefix;

  assign offsetFromPrefix = reqAddr - prefixReg;

  always_comb begin
    if (reqAddr < SPAN) begin
      mapped = reqAddr + prefixReg;
    end else if ((reqAddr >= prefixReg) && (offsetFromPrefix < SPAN)) begin
      mapped = offsetFromPrefix;
    end else begin
      mapped = reqAddr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prefixReg <= '0;
    end else if (prefixWe) begin
      prefixReg <= {prefixIn[ADDR_W-1:PREFIX_BITS], {PREFIX_BITS{1'b0}}};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid     <= 1'b0;
      absAddr      <= '0;
      protExc      <= 1'b0;
      noWriteCache <= 1'b0;
      modeErr      <= 1'b0;
    end else begin
      rspValid     <= reqValid;
      absAddr      <= (reqValid && !strb.protHit && !strb.modeErr) ? mapped : '0;
      protExc      <= strb.protHit;
      noWriteCache <= strb.noCache;
      modeErr      <= strb.modeErr;
    end
  end

  AST_RESP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid); // R11

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> (!protExc && !noWriteCache && !modeErr && absAddr == '0)); // R11

  AST_EXC_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && protExc) |-> (absAddr == '0)); // R6

  AST_PASS_BELOW_PREFIX: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !strb.protHit && !strb.modeErr && reqAddr >= SPAN &&
     reqAddr < prefixReg) |=> (absAddr == $past(reqAddr))); // R8

endmodule

// File: rtl/lapp_unit.sv
module lapp_unit
  import lapp_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int PAGE_BITS   = 12,
  parameter int WIN_BITS    = 9,
  parameter int LOW_PAGES   = 2,
  parameter int PREFIX_BITS = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        accKind,
  input  logic              realMode,
  input  logic              datOn,
  input  logic [1:0]        spaceSel,
  input  logic [2:0]        privBits,
  input  logic              lowProtCtl,
  input  logic              prefixWe,
  input  logic [ADDR_W-1:0] prefixIn,
  output logic              rspValid,
  output logic [ADDR_W-1:0] absAddr,
  output logic              protExc,
  output logic              noWriteCache,
  output logic              modeErr
);

  lapp_strobe_t strb;

  lapp_ctrl #(
    .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS),
    .WIN_BITS(WIN_BITS), .LOW_PAGES(LOW_PAGES)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .accKind(accKind), .realMode(realMode), .datOn(datOn),
    .spaceSel(spaceSel), .privBits(privBits), .lowProtCtl(lowProtCtl),
    .strb(strb)
  );

  lapp_datapath #(
    .ADDR_W(ADDR_W), .PREFIX_BITS(PREFIX_BITS)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .strb(strb), .prefixWe(prefixWe), .prefixIn(prefixIn),
    .rspValid(rspValid), .absAddr(absAddr), .protExc(protExc),
    .noWriteCache(noWriteCache), .modeErr(modeErr)
  );

endmodule

// File: tb/test_lapp_unit.sv
module test_lapp_unit;

  typedef struct packed {
    logic [31:0] absAddr;
    logic        exc;
    logic        nc;
    logic        err;
  } exp_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [1:0]  accKind = '0;
  logic        realMode = 1'b0;
  logic        datOn = 1'b0;
  logic [1:0]  spaceSel = '0;
  logic [2:0]  privBits = '0;
  logic        lowProtCtl = 1'b0;
  logic        prefixWe = 1'b0;
  logic [31:0] prefixIn = '0;
  logic        rspValid;
  logic [31:0] absAddr;
  logic        protExc;
  logic        noWriteCache;
  logic        modeErr;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [31:0] modelPrefix = '0;
  exp_t  expQ[$];
  string tagQ[$];

  always #2 clk = ~clk;

  lapp_unit i_lapp_unit (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .accKind(accKind), .realMode(realMode), .datOn(datOn),
    .spaceSel(spaceSel), .privBits(privBits), .lowProtCtl(lowProtCtl),
    .prefixWe(prefixWe), .prefixIn(prefixIn), .rspValid(rspValid),
    .absAddr(absAddr), .protExc(protExc), .noWriteCache(noWriteCache),
    .modeErr(modeErr)
  );

  function automatic exp_t model(logic [31:0] a, logic [1:0] k, logic rm,
                                 logic dat, logic [1:0] sel, logic [2:0] pv,
                                 logic lp, logic [31:0] pfx);
    exp_t e;
    logic en, win, low;
    e.err = !rm && (sel == 2'd3);
    if (rm) en = lp;
    else    en = lp && dat && (sel != 2'd3) && !pv[sel];
    win = (a <= 32'd511) || (a >= 32'd4096 && a <= 32'd4607);
    low = a < 32'h2000;
    e.exc = !e.err && en && win && (k == 2'd1);
    e.nc  = !e.err && en && low;
    if (e.err || e.exc)                          e.absAddr = '0;
    else if (a < 32'h2000)                       e.absAddr = a + pfx;
    else if (a >= pfx && a < pfx + 32'h2000)     e.absAddr = a - pfx;
    else                                         e.absAddr = a;
    return e;
  endfunction

  task automatic req(string tag, logic [31:0] a, logic [1:0] k, logic rm,
                     logic dat, logic [1:0] sel, logic [2:0] pv, logic lp);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; accKind = k; realMode = rm; datOn = dat;
    spaceSel = sel; privBits = pv; lowProtCtl = lp; prefixWe = 1'b0;
    expQ.push_back(model(a, k, rm, dat, sel, pv, lp, modelPrefix));
    tagQ.push_back(tag);
  endtask

  task automatic reqWithPrefix(string tag, logic [31:0] a, logic [31:0] p);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; accKind = 2'd0; realMode = 1'b1;
    datOn = 1'b0; spaceSel = 2'd0; privBits = '0; lowProtCtl = 1'b0;
    prefixWe = 1'b1; prefixIn = p;
    expQ.push_back(model(a, 2'd0, 1'b1, 1'b0, 2'd0, 3'd0, 1'b0, modelPrefix));
    tagQ.push_back(tag);
    modelPrefix = p & 32'hFFFF_E000;
  endtask

  task automatic writePrefix(logic [31:0] p);
    @(negedge clk);
    reqValid = 1'b0; prefixWe = 1'b1; prefixIn = p;
    @(negedge clk);
    prefixWe = 1'b0;
    modelPrefix = p & 32'hFFFF_E000;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      reqValid = 1'b0; prefixWe = 1'b0;
    end
  endtask

  // Monitor: compares each response against the scoreboard head
  always @(negedge clk) begin
    if (rstN && !done) begin
      checks++;
      if (rspValid) begin
        if (expQ.size() == 0) begin
          errors++;
          $display("FAIL R11: unexpected response abs=%h", absAddr);
        end else begin
          exp_t e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          if (absAddr !== e.absAddr || protExc !== e.exc ||
              noWriteCache !== e.nc || modeErr !== e.err) begin
            errors++;
            $display("FAIL %s: abs=%h exc=%b nc=%b err=%b expected abs=%h exc=%b nc=%b err=%b",
                     t, absAddr, protExc, noWriteCache, modeErr,
                     e.absAddr, e.exc, e.nc, e.err);
          end
        end
      end else if (absAddr !== '0 || protExc || noWriteCache || modeErr) begin
        errors++;
        $display("FAIL R11: idle outputs abs=%h exc=%b nc=%b err=%b expected all 0",
                 absAddr, protExc, noWriteCache, modeErr);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (rspValid !== 1'b0 || absAddr !== '0 || protExc !== 1'b0) begin
      errors++;
      $display("FAIL R11: reset state rsp=%b abs=%h exc=%b expected 0", rspValid, absAddr, protExc);
    end
    rstN = 1'b1;

    // R9 reset prefix of zero, R7
    req("R9_reset_prefix", 32'h100, 2'd0, 1, 0, 0, 3'd0, 0);
    idle(1);
    writePrefix(32'h0001_5ABC);   // R9: aligns down to 0x14000
    req("R7_low_plus",      32'h10,    2'd0, 1, 0, 0, 3'd0, 0);
    req("R8_area_minus",    32'h14020, 2'd0, 1, 0, 0, 3'd0, 0);
    req("R8_area_top",      32'h15FFF, 2'd0, 1, 0, 0, 3'd0, 0);
    req("R8_above_area",    32'h16000, 2'd0, 1, 0, 0, 3'd0, 0);
    req("R8_below_area",    32'h3000,  2'd0, 1, 0, 0, 3'd0, 0);
    req("R7_low_edge",      32'h1FFF,  2'd0, 1, 0, 0, 3'd0, 0);
    reqWithPrefix("R9_same_cycle_old", 32'h10, 32'h0004_0000);
    req("R9_next_uses_new", 32'h10,    2'd0, 1, 0, 0, 3'd0, 0);

    // R1 window edges in real mode with protection on, R5, R6
    req("R1_store_0",    32'd0,    2'd1, 1, 0, 0, 3'd0, 1);
    req("R1_store_511",  32'd511,  2'd1, 1, 0, 0, 3'd0, 1);
    req("R1_store_512",  32'd512,  2'd1, 1, 0, 0, 3'd0, 1);
    req("R1_store_4095", 32'd4095, 2'd1, 1, 0, 0, 3'd0, 1);
    req("R1_store_4096", 32'd4096, 2'd1, 1, 0, 0, 3'd0, 1);
    req("R1_store_4607", 32'd4607, 2'd1, 1, 0, 0, 3'd0, 1);
    req("R1_store_4608", 32'd4608, 2'd1, 1, 0, 0, 3'd0, 1);
    req("R4_store_8192", 32'd8192, 2'd1, 1, 0, 0, 3'd0, 1);
    req("R6_exc_zero_addr", 32'd300, 2'd1, 1, 0, 0, 3'd0, 1);
    req("R5_fetch_0",    32'd0,    2'd0, 1, 0, 0, 3'd0, 1);
    req("R5_ifetch_0",   32'd0,    2'd2, 1, 0, 0, 3'd0, 1);
    req("R5_kind3_0",    32'd0,    2'd3, 1, 0, 0, 3'd0, 1);
    idle(2);

    // R3 real mode enable ignores translation state
    req("R3_real_ignores_priv", 32'd8, 2'd1, 1, 0, 2'd0, 3'b111, 1);
    req("R3_real_lp_off",       32'd8, 2'd1, 1, 1, 2'd0, 3'b000, 0);
    req("R10_real_space3_ok",   32'd8, 2'd1, 1, 1, 2'd3, 3'b000, 1);

    // R2 translated mode enables per space
    req("R2_primary_clear",   32'd16, 2'd1, 0, 1, 2'd0, 3'b000, 1);
    req("R2_primary_private", 32'd16, 2'd1, 0, 1, 2'd0, 3'b001, 1);
    req("R2_secondary_clear", 32'd16, 2'd1, 0, 1, 2'd1, 3'b101, 1);
    req("R2_secondary_priv",  32'd16, 2'd1, 0, 1, 2'd1, 3'b010, 1);
    req("R2_home_clear",      32'd4100, 2'd1, 0, 1, 2'd2, 3'b011, 1);
    req("R2_home_private",    32'd4100, 2'd1, 0, 1, 2'd2, 3'b100, 1);
    req("R2_dat_off",         32'd16, 2'd1, 0, 0, 2'd0, 3'b000, 1);
    req("R2_lp_off",          32'd16, 2'd1, 0, 1, 2'd0, 3'b000, 0);
    req("R4_translated_page1_fetch", 32'd4700, 2'd0, 0, 1, 2'd0, 3'b000, 1);

    // R10 unsupported space in translated mode
    req("R10_space3_store", 32'd0,      2'd1, 0, 1, 2'd3, 3'b000, 1);
    req("R10_space3_high",  32'h50000,  2'd0, 0, 0, 2'd3, 3'b000, 0);
    idle(4);

    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R11: %0d responses missing, expected 0", expQ.size());
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule